// File: doc/BRIEF.md
# Packet and Sideband Stream Merger with Matching Splitter

The block joins two streams that arrive separately. One carries packet beats (data, byte keep, last-beat flag). The other carries one metadata tuple per packet together with a two-bit decision code. The merger pairs them one to one and in order, and emits a single combined stream. On it every packet beat carries the tuple on TUSER and the decision on TDEST. The merger captures each tuple into a single holding register. It repeats that tuple unchanged on every beat of the packet, up to and including the beat with TLAST. It releases the register on the cycle that last beat is accepted downstream.

The same block also contains the reverse function. A splitter takes a combined stream and passes TDATA, TKEEP and TLAST through untouched. It takes TUSER and TDEST from the first beat of each packet and emits them on two separate output streams, tuple and decision, once per packet.

All data interfaces are valid/ready. A transfer happens on a rising clock edge when valid and ready are both high. A source holds valid and its payload steady until the transfer. On the merger, output back-pressure goes straight through to the packet input. A new tuple is taken only when the holding register is empty, or when it is being freed in that same cycle. On the splitter, the first beat of a packet waits until both sideband output registers are empty. Later beats depend only on the packet output's ready.

Top module: `axis_tuple_merge_split`

## Requirements
- R1: A merged output beat carries the packet input's TDATA, TKEEP and TLAST unchanged. mg_tvalid is high exactly when pk_tvalid is high and a tuple is held.
- R2: While no tuple is held, pk_tready and mg_tvalid are both low.
- R3: tu_tready is high only when no tuple is held, or when the held tuple's final beat (TLAST high) transfers on the merged output in that same cycle.
- R4: Every beat of a packet on the merged output carries on TUSER the tuple paired with that packet, and on TDEST its 2-bit decision. The pairing is strictly in arrival order, one tuple per packet, and the values are unchanged from the first beat through the TLAST beat.
- R5: The splitter passes TDATA, TKEEP and TLAST of each combined beat unchanged to its packet output, in order, with no beat dropped or repeated.
- R6: For each packet, the splitter emits exactly one tuple transfer and one decision transfer. Their values are TUSER and TDEST of the packet's first beat, in packet order. Each output holds valid and its data steady until it is taken.
- R7: The first beat of a packet at the splitter input is not accepted while the tuple output or the decision output still holds an untaken value. Later beats of a packet are accepted whenever the packet output is ready.
- R8: After reset, mg_tvalid, sp_tvalid, st_tvalid and sd_tvalid are low, and tu_tready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pk_tvalid | input | 1 | Packet input valid |
| pk_tready | output | 1 | Packet input ready |
| pk_tdata | input | DATA_W | Packet input data |
| pk_tkeep | input | DATA_W/8 | Packet input byte keep |
| pk_tlast | input | 1 | Packet input last beat |
| tu_tvalid | input | 1 | Tuple input valid |
| tu_tready | output | 1 | Tuple input ready |
| tu_tdata | input | TUPLE_W | Tuple input value |
| tu_tdest | input | DEST_W | Decision code paired with the tuple |
| mg_tvalid | output | 1 | Merged output valid |
| mg_tready | input | 1 | Merged output ready |
| mg_tdata | output | DATA_W | Merged output data |
| mg_tkeep | output | DATA_W/8 | Merged output byte keep |
| mg_tlast | output | 1 | Merged output last beat |
| mg_tuser | output | TUPLE_W | Merged output tuple |
| mg_tdest | output | DEST_W | Merged output decision |
| cb_tvalid | input | 1 | Combined input valid (splitter) |
| cb_tready | output | 1 | Combined input ready |
| cb_tdata | input | DATA_W | Combined input data |
| cb_tkeep | input | DATA_W/8 | Combined input byte keep |
| cb_tlast | input | 1 | Combined input last beat |
| cb_tuser | input | TUPLE_W | Combined input tuple |
| cb_tdest | input | DEST_W | Combined input decision |
| sp_tvalid | output | 1 | Split packet output valid |
| sp_tready | input | 1 | Split packet output ready |
| sp_tdata | output | DATA_W | Split packet output data |
| sp_tkeep | output | DATA_W/8 | Split packet output byte keep |
| sp_tlast | output | 1 | Split packet output last beat |
| st_tvalid | output | 1 | Split tuple output valid |
| st_tready | input | 1 | Split tuple output ready |
| st_tdata | output | TUPLE_W | Split tuple output value |
| sd_tvalid | output | 1 | Split decision output valid |
| sd_tready | input | 1 | Split decision output ready |
| sd_tdata | output | DEST_W | Split decision output value |

## Verification
The bench builds the block with its defaults: 64-bit data, 64-bit tuple, 2-bit decision. It wires the merged output back into the splitter input, so each packet goes through both halves and returns as a packet, a tuple and a decision. Packets of one to four beats include single-beat ones. These reach the cycle where a held tuple is freed and the next one is loaded together. Random gaps on both inputs let the tuple arrive both before and after its packet. An early window with the tuple sink stalled fills the splitter's sideband registers and blocks the next first beat.

// File: rtl/axis_join_pkg.sv
package axis_join_pkg;

  localparam int unsigned DEF_DATA_W  = 64;
  localparam int unsigned DEF_TUPLE_W = 64;
  localparam int unsigned DEF_DEST_W  = 2;

  typedef enum logic {
    PH_HEAD = 1'b0,
    PH_BODY = 1'b1
  } split_phase_e;

endpackage

// File: rtl/sb_hold.sv
module sb_hold #(
  parameter int unsigned TUPLE_W = 64,
  parameter int unsigned DEST_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               release_i,
  input  logic [TUPLE_W-1:0] load_tuple,
  input  logic [DEST_W-1:0]  load_dest,
  output logic               full,
  output logic [TUPLE_W-1:0] tuple,
  output logic [DEST_W-1:0]  dest
);

  logic               full_q;
  logic [TUPLE_W-1:0] tuple_q;
  logic [DEST_W-1:0]  dest_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (load) begin
      full_q <= 1'b1;
    end else if (release_i) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tuple_q <= '0;
      dest_q  <= '0;
    end else if (load) begin
      tuple_q <= load_tuple;
      dest_q  <= load_dest;
    end
  end

  assign full  = full_q;
  assign tuple = tuple_q;
  assign dest  = dest_q;

endmodule

// File: rtl/tup_join.sv
module tup_join #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned TUPLE_W = 64,
  parameter int unsigned DEST_W  = 2,
  localparam int unsigned KEEP_W = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pk_tvalid,
  output logic               pk_tready,
  input  logic [DATA_W-1:0]  pk_tdata,
  input  logic [KEEP_W-1:0]  pk_tkeep,
  input  logic               pk_tlast,
  input  logic               tu_tvalid,
  output logic               tu_tready,
  input  logic [TUPLE_W-1:0] tu_tdata,
  input  logic [DEST_W-1:0]  tu_tdest,
  output logic               mg_tvalid,
  input  logic               mg_tready,
  output logic [DATA_W-1:0]  mg_tdata,
  output logic [KEEP_W-1:0]  mg_tkeep,
  output logic               mg_tlast,
  output logic [TUPLE_W-1:0] mg_tuser,
  output logic [DEST_W-1:0]  mg_tdest
);

  logic               held;
  logic [TUPLE_W-1:0] held_tuple;
  logic [DEST_W-1:0]  held_dest;
  logic               beat_go;
  logic               pkt_done;
  logic               take_tuple;

  assign beat_go    = pk_tvalid && held && mg_tready;
  assign pkt_done   = beat_go && pk_tlast;
  assign tu_tready  = !held || pkt_done;
  assign take_tuple = tu_tvalid && tu_tready;

  sb_hold #(
    .TUPLE_W(TUPLE_W),
    .DEST_W (DEST_W)
  ) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_tuple),
    .release_i (pkt_done),
    .load_tuple(tu_tdata),
    .load_dest (tu_tdest),
    .full      (held),
    .tuple     (held_tuple),
    .dest      (held_dest)
  );

  always_comb begin
    pk_tready = held && mg_tready;
    mg_tvalid = held && pk_tvalid;
    mg_tdata  = pk_tdata;
    mg_tkeep  = pk_tkeep;
    mg_tlast  = pk_tlast;
    mg_tuser  = held_tuple;
    mg_tdest  = held_dest;
  end

endmodule

// File: rtl/side_slot.sv
module side_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fill,
  input  logic [W-1:0] fill_data,
  output logic         empty,
  output logic         o_tvalid,
  input  logic         o_tready,
  output logic [W-1:0] o_tdata
);

  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (fill) begin
      full_q <= 1'b1;
    end else if (o_tready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (fill) begin
      data_q <= fill_data;
    end
  end

  assign empty    = !full_q;
  assign o_tvalid = full_q;
  assign o_tdata  = data_q;

endmodule

// File: rtl/tup_split.sv
module tup_split
  import axis_join_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned TUPLE_W = 64,
  parameter int unsigned DEST_W  = 2,
  localparam int unsigned KEEP_W = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cb_tvalid,
  output logic               cb_tready,
  input  logic [DATA_W-1:0]  cb_tdata,
  input  logic [KEEP_W-1:0]  cb_tkeep,
  input  logic               cb_tlast,
  input  logic [TUPLE_W-1:0] cb_tuser,
  input  logic [DEST_W-1:0]  cb_tdest,
  output logic               sp_tvalid,
  input  logic               sp_tready,
  output logic [DATA_W-1:0]  sp_tdata,
  output logic [KEEP_W-1:0]  sp_tkeep,
  output logic               sp_tlast,
  output logic               st_tvalid,
  input  logic               st_tready,
  output logic [TUPLE_W-1:0] st_tdata,
  output logic               sd_tvalid,
  input  logic               sd_tready,
  output logic [DEST_W-1:0]  sd_tdata
);

  split_phase_e phase_q;
  logic         t_empty;
  logic         d_empty;
  logic         gate;
  logic         beat_go;
  logic         head_go;

  assign gate      = (phase_q == PH_BODY) || (t_empty && d_empty);
  assign cb_tready = sp_tready && gate;
  assign sp_tvalid = cb_tvalid && gate;
  assign sp_tdata  = cb_tdata;
  assign sp_tkeep  = cb_tkeep;
  assign sp_tlast  = cb_tlast;
  assign beat_go   = cb_tvalid && cb_tready;
  assign head_go   = beat_go && (phase_q == PH_HEAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_HEAD;
    end else if (beat_go) begin
      phase_q <= cb_tlast ? PH_HEAD : PH_BODY;
    end
  end

  side_slot #(.W(TUPLE_W)) u_tslot (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill     (head_go),
    .fill_data(cb_tuser),
    .empty    (t_empty),
    .o_tvalid (st_tvalid),
    .o_tready (st_tready),
    .o_tdata  (st_tdata)
  );

  side_slot #(.W(DEST_W)) u_dslot (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill     (head_go),
    .fill_data(cb_tdest),
    .empty    (d_empty),
    .o_tvalid (sd_tvalid),
    .o_tready (sd_tready),
    .o_tdata  (sd_tdata)
  );

endmodule

// File: rtl/axis_tuple_merge_split.sv
module axis_tuple_merge_split
  import axis_join_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned TUPLE_W = DEF_TUPLE_W,
  parameter int unsigned DEST_W  = DEF_DEST_W,
  localparam int unsigned KEEP_W = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pk_tvalid,
  output logic               pk_tready,
  input  logic [DATA_W-1:0]  pk_tdata,
  input  logic [KEEP_W-1:0]  pk_tkeep,
  input  logic               pk_tlast,
  input  logic               tu_tvalid,
  output logic               tu_tready,
  input  logic [TUPLE_W-1:0] tu_tdata,
  input  logic [DEST_W-1:0]  tu_tdest,
  output logic               mg_tvalid,
  input  logic               mg_tready,
  output logic [DATA_W-1:0]  mg_tdata,
  output logic [KEEP_W-1:0]  mg_tkeep,
  output logic               mg_tlast,
  output logic [TUPLE_W-1:0] mg_tuser,
  output logic [DEST_W-1:0]  mg_tdest,
  input  logic               cb_tvalid,
  output logic               cb_tready,
  input  logic [DATA_W-1:0]  cb_tdata,
  input  logic [KEEP_W-1:0]  cb_tkeep,
  input  logic               cb_tlast,
  input  logic [TUPLE_W-1:0] cb_tuser,
  input  logic [DEST_W-1:0]  cb_tdest,
  output logic               sp_tvalid,
  input  logic               sp_tready,
  output logic [DATA_W-1:0]  sp_tdata,
  output logic [KEEP_W-1:0]  sp_tkeep,
  output logic               sp_tlast,
  output logic               st_tvalid,
  input  logic               st_tready,
  output logic [TUPLE_W-1:0] st_tdata,
  output logic               sd_tvalid,
  input  logic               sd_tready,
  output logic [DEST_W-1:0]  sd_tdata
);

  tup_join #(
    .DATA_W (DATA_W),
    .TUPLE_W(TUPLE_W),
    .DEST_W (DEST_W)
  ) u_join (
    .clk      (clk),
    .rst_n    (rst_n),
    .pk_tvalid(pk_tvalid),
    .pk_tready(pk_tready),
    .pk_tdata (pk_tdata),
    .pk_tkeep (pk_tkeep),
    .pk_tlast (pk_tlast),
    .tu_tvalid(tu_tvalid),
    .tu_tready(tu_tready),
    .tu_tdata (tu_tdata),
    .tu_tdest (tu_tdest),
    .mg_tvalid(mg_tvalid),
    .mg_tready(mg_tready),
    .mg_tdata (mg_tdata),
    .mg_tkeep (mg_tkeep),
    .mg_tlast (mg_tlast),
    .mg_tuser (mg_tuser),
    .mg_tdest (mg_tdest)
  );

  tup_split #(
    .DATA_W (DATA_W),
    .TUPLE_W(TUPLE_W),
    .DEST_W (DEST_W)
  ) u_split (
    .clk      (clk),
    .rst_n    (rst_n),
    .cb_tvalid(cb_tvalid),
    .cb_tready(cb_tready),
    .cb_tdata (cb_tdata),
    .cb_tkeep (cb_tkeep),
    .cb_tlast (cb_tlast),
    .cb_tuser (cb_tuser),
    .cb_tdest (cb_tdest),
    .sp_tvalid(sp_tvalid),
    .sp_tready(sp_tready),
    .sp_tdata (sp_tdata),
    .sp_tkeep (sp_tkeep),
    .sp_tlast (sp_tlast),
    .st_tvalid(st_tvalid),
    .st_tready(st_tready),
    .st_tdata (st_tdata),
    .sd_tvalid(sd_tvalid),
    .sd_tready(sd_tready),
    .sd_tdata (sd_tdata)
  );

endmodule

// File: rtl/axis_tuple_merge_split_chk.sv
module axis_tuple_merge_split_chk #(
  parameter int unsigned TUPLE_W = 64,
  parameter int unsigned DEST_W  = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pk_tready,
  input logic               tu_tvalid,
  input logic               tu_tready,
  input logic               mg_tvalid,
  input logic               mg_tready,
  input logic               mg_tlast,
  input logic [TUPLE_W-1:0] mg_tuser,
  input logic [DEST_W-1:0]  mg_tdest,
  input logic               cb_tvalid,
  input logic               cb_tready,
  input logic               cb_tlast,
  input logic               st_tvalid,
  input logic               st_tready,
  input logic [TUPLE_W-1:0] st_tdata,
  input logic               sd_tvalid,
  input logic               sd_tready,
  input logic [DEST_W-1:0]  sd_tdata
);

  logic               held_c;
  logic               mid_c;
  logic               head_c;
  logic [TUPLE_W-1:0] user_c;
  logic [DEST_W-1:0]  dest_c;
  logic               mg_go;

  assign mg_go = mg_tvalid && mg_tready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_c <= 1'b0;
      mid_c  <= 1'b0;
      head_c <= 1'b1;
      user_c <= '0;
      dest_c <= '0;
    end else begin
      if (tu_tvalid && tu_tready) begin
        held_c <= 1'b1;
      end else if (mg_go && mg_tlast) begin
        held_c <= 1'b0;
      end
      if (mg_go) begin
        mid_c  <= !mg_tlast;
        user_c <= mg_tuser;
        dest_c <= mg_tdest;
      end
      if (cb_tvalid && cb_tready) begin
        head_c <= cb_tlast;
      end
    end
  end

  AST_PKT_WAITS_TUPLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pk_tready || mg_tvalid) |-> held_c); // R2

  AST_TUPLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tu_tready |-> (!held_c || (mg_go && mg_tlast))); // R3

  AST_SIDEBAND_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_c && mg_go) |-> (mg_tuser == user_c && mg_tdest == dest_c)); // R4

  AST_TUPLE_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_tvalid && !st_tready) |=> (st_tvalid && $stable(st_tdata))); // R6

  AST_DEC_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_tvalid && !sd_tready) |=> (sd_tvalid && $stable(sd_tdata))); // R6

  AST_HEAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (head_c && cb_tready) |-> (!st_tvalid && !sd_tvalid)); // R7

endmodule

bind axis_tuple_merge_split axis_tuple_merge_split_chk #(
  .TUPLE_W(TUPLE_W),
  .DEST_W (DEST_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pk_tready(pk_tready),
  .tu_tvalid(tu_tvalid),
  .tu_tready(tu_tready),
  .mg_tvalid(mg_tvalid),
  .mg_tready(mg_tready),
  .mg_tlast (mg_tlast),
  .mg_tuser (mg_tuser),
  .mg_tdest (mg_tdest),
  .cb_tvalid(cb_tvalid),
  .cb_tready(cb_tready),
  .cb_tlast (cb_tlast),
  .st_tvalid(st_tvalid),
  .st_tready(st_tready),
  .st_tdata (st_tdata),
  .sd_tvalid(sd_tvalid),
  .sd_tready(sd_tready),
  .sd_tdata (sd_tdata)
);

// File: tb/sim_axis_tuple_merge_split.sv
`timescale 1ns/1ps
module sim_axis_tuple_merge_split;

  localparam int DATA_W  = 64;
  localparam int TUPLE_W = 64;
  localparam int DEST_W  = 2;
  localparam int KEEP_W  = DATA_W / 8;
  localparam int NPKT    = 80;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic               pk_tvalid = 1'b0, pk_tready, pk_tlast = 1'b0;
  logic [DATA_W-1:0]  pk_tdata = '0;
  logic [KEEP_W-1:0]  pk_tkeep = '0;
  logic               tu_tvalid = 1'b0, tu_tready;
  logic [TUPLE_W-1:0] tu_tdata = '0;
  logic [DEST_W-1:0]  tu_tdest = '0;
  logic               mg_tvalid, mg_tlast;
  logic [DATA_W-1:0]  mg_tdata;
  logic [KEEP_W-1:0]  mg_tkeep;
  logic [TUPLE_W-1:0] mg_tuser;
  logic [DEST_W-1:0]  mg_tdest;
  logic               cb_tready;
  logic               sp_tvalid, sp_tlast;
  logic               sp_tready = 1'b0;
  logic [DATA_W-1:0]  sp_tdata;
  logic [KEEP_W-1:0]  sp_tkeep;
  logic               st_tvalid;
  logic               st_tready = 1'b0;
  logic [TUPLE_W-1:0] st_tdata;
  logic               sd_tvalid;
  logic               sd_tready = 1'b0;
  logic [DEST_W-1:0]  sd_tdata;

  axis_tuple_merge_split #(
    .DATA_W(DATA_W), .TUPLE_W(TUPLE_W), .DEST_W(DEST_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .pk_tvalid(pk_tvalid), .pk_tready(pk_tready), .pk_tdata(pk_tdata),
    .pk_tkeep(pk_tkeep), .pk_tlast(pk_tlast),
    .tu_tvalid(tu_tvalid), .tu_tready(tu_tready), .tu_tdata(tu_tdata),
    .tu_tdest(tu_tdest),
    .mg_tvalid(mg_tvalid), .mg_tready(cb_tready), .mg_tdata(mg_tdata),
    .mg_tkeep(mg_tkeep), .mg_tlast(mg_tlast), .mg_tuser(mg_tuser),
    .mg_tdest(mg_tdest),
    .cb_tvalid(mg_tvalid), .cb_tready(cb_tready), .cb_tdata(mg_tdata),
    .cb_tkeep(mg_tkeep), .cb_tlast(mg_tlast), .cb_tuser(mg_tuser),
    .cb_tdest(mg_tdest),
    .sp_tvalid(sp_tvalid), .sp_tready(sp_tready), .sp_tdata(sp_tdata),
    .sp_tkeep(sp_tkeep), .sp_tlast(sp_tlast),
    .st_tvalid(st_tvalid), .st_tready(st_tready), .st_tdata(st_tdata),
    .sd_tvalid(sd_tvalid), .sd_tready(sd_tready), .sd_tdata(sd_tdata)
  );

  int                 plen [NPKT];
  logic [TUPLE_W-1:0] tupv [NPKT];
  logic [DEST_W-1:0]  decv [NPKT];
  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  function automatic logic [DATA_W-1:0] exp_data(int i, int b);
    return {16'(i), 16'(b), tupv[i][31:0]};
  endfunction

  function automatic logic [KEEP_W-1:0] exp_keep(int i, int b);
    if (b == plen[i] - 1) return KEEP_W'(8'hFF >> (i % 8));
    return '1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  initial begin
    void'($urandom(32'd7731));
    for (int i = 0; i < NPKT; i++) begin
      plen[i] = 1 + int'($urandom % 4);
      if (i < 4) plen[i] = 1;
      tupv[i] = {$urandom, $urandom};
      decv[i] = DEST_W'($urandom % 4);
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  // packet source
  initial begin
    @(posedge rst_n);
    repeat (3) @(negedge clk);
    for (int i = 0; i < NPKT; i++) begin
      for (int b = 0; b < plen[i]; b++) begin
        repeat ($urandom % 3) begin
          @(negedge clk);
          pk_tvalid = 1'b0;
        end
        @(negedge clk);
        pk_tvalid = 1'b1;
        pk_tdata  = exp_data(i, b);
        pk_tkeep  = exp_keep(i, b);
        pk_tlast  = (b == plen[i] - 1);
        #1;
        while (!pk_tready) begin
          @(negedge clk);
          #1;
        end
      end
    end
    @(negedge clk);
    pk_tvalid = 1'b0;
  end

  // tuple source: first tuple late so the packet must wait (R2)
  initial begin
    @(posedge rst_n);
    repeat (8) @(negedge clk);
    for (int i = 0; i < NPKT; i++) begin
      repeat ($urandom % 5) begin
        @(negedge clk);
        tu_tvalid = 1'b0;
      end
      @(negedge clk);
      tu_tvalid = 1'b1;
      tu_tdata  = tupv[i];
      tu_tdest  = decv[i];
      #1;
      while (!tu_tready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    tu_tvalid = 1'b0;
  end

  // sinks: tuple sink stalled for an early window (R7)
  initial begin
    @(posedge rst_n);
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      sp_tready = 1'b1;
      st_tready = 1'b0;
      sd_tready = 1'b1;
    end
    forever begin
      @(negedge clk);
      sp_tready = ($urandom % 4) != 0;
      st_tready = ($urandom % 3) != 0;
      sd_tready = ($urandom % 3) != 0;
    end
  end

  int  mo_p = 0, mo_b = 0, so_p = 0, so_b = 0, st_i = 0, sd_i = 0;
  bit  held_b = 1'b0;
  bit  head_b = 1'b1;
  bit  mg_go, sp_go;

  // monitor
  initial begin
    @(posedge rst_n);
    @(negedge clk);
    #1;
    check(!mg_tvalid, "R8 mg_tvalid", 128'(mg_tvalid), 128'(0));
    check(!sp_tvalid, "R8 sp_tvalid", 128'(sp_tvalid), 128'(0));
    check(!st_tvalid && !sd_tvalid, "R8 side valid", 128'({st_tvalid, sd_tvalid}), 128'(0));
    check(tu_tready, "R8 tu_tready", 128'(tu_tready), 128'(1));
    forever begin
      @(negedge clk);
      #1.5;
      mg_go = mg_tvalid && cb_tready;
      sp_go = sp_tvalid && sp_tready;
      if (!held_b)
        check(!pk_tready && !mg_tvalid, "R2 stall without tuple",
              128'({pk_tready, mg_tvalid}), 128'(0));
      if (tu_tvalid && held_b && !(mg_go && mg_tlast))
        check(!tu_tready, "R3 tuple gated", 128'(tu_tready), 128'(0));
      if (mg_tvalid && head_b && (st_tvalid || sd_tvalid))
        check(!cb_tready, "R7 head stalled", 128'(cb_tready), 128'(0));
      if (mg_tvalid && !head_b)
        check(cb_tready == sp_tready, "R7 body follows ready",
              128'(cb_tready), 128'(sp_tready));
      if (held_b && pk_tvalid)
        check(mg_tvalid, "R1 valid passes", 128'(mg_tvalid), 128'(1));
      if (mg_go) begin
        if (mo_p < NPKT) begin
          check(mg_tdata == exp_data(mo_p, mo_b), "R1 data", 128'(mg_tdata),
                128'(exp_data(mo_p, mo_b)));
          check(mg_tkeep == exp_keep(mo_p, mo_b) &&
                mg_tlast == (mo_b == plen[mo_p] - 1), "R1 keep/last",
                128'({mg_tkeep, mg_tlast}),
                128'({exp_keep(mo_p, mo_b), mo_b == plen[mo_p] - 1}));
          check(mg_tuser == tupv[mo_p] && mg_tdest == decv[mo_p], "R4 sideband",
                128'({mg_tuser, mg_tdest}), 128'({tupv[mo_p], decv[mo_p]}));
          if (mo_b == plen[mo_p] - 1) begin
            mo_p++;
            mo_b = 0;
          end else mo_b++;
        end else check(0, "R4 extra merged beat", 128'(mg_tdata), 128'(0));
      end
      if (sp_go) begin
        if (so_p < NPKT) begin
          check(sp_tdata == exp_data(so_p, so_b) && sp_tkeep == exp_keep(so_p, so_b)
                && sp_tlast == (so_b == plen[so_p] - 1), "R5 split beat",
                128'({sp_tdata, sp_tkeep, sp_tlast}),
                128'({exp_data(so_p, so_b), exp_keep(so_p, so_b), so_b == plen[so_p] - 1}));
          if (so_b == plen[so_p] - 1) begin
            so_p++;
            so_b = 0;
          end else so_b++;
        end else check(0, "R5 extra split beat", 128'(sp_tdata), 128'(0));
      end
      if (st_tvalid && st_tready) begin
        if (st_i < NPKT)
          check(st_tdata == tupv[st_i] && st_i < so_p + 1, "R6 tuple out",
                128'(st_tdata), 128'(tupv[st_i]));
        else check(0, "R6 extra tuple", 128'(st_tdata), 128'(0));
        st_i++;
      end
      if (sd_tvalid && sd_tready) begin
        if (sd_i < NPKT)
          check(sd_tdata == decv[sd_i], "R6 decision out", 128'(sd_tdata),
                128'(decv[sd_i]));
        else check(0, "R6 extra decision", 128'(sd_tdata), 128'(0));
        sd_i++;
      end
      if (tu_tvalid && tu_tready) held_b = 1'b1;
      else if (mg_go && mg_tlast) held_b = 1'b0;
      if (mg_go) head_b = mg_tlast;
    end
  end

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        wait (mo_p == NPKT && so_p == NPKT && st_i == NPKT && sd_i == NPKT);
        repeat (10) @(negedge clk);
      end
      begin
        repeat (40000) @(negedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out)
      check(0, "R4 watchdog expired", 128'(mo_p), 128'(NPKT));
    check(st_i == NPKT && sd_i == NPKT, "R6 one sideband per packet",
          128'({32'(st_i), 32'(sd_i)}), 128'({32'(NPKT), 32'(NPKT)}));
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule